// File: doc/BRIEF.md
# Tagged Token Pairing Store

This block sits in the ring of a tagged-token dataflow machine, between the token queue and the instruction fetch stage. Every token that arrives names the instruction it is headed for (destination) and the activation it belongs to (label). A binary instruction may fire only when both of its operands carrying the same label and destination are present. The block finds those pairs.

An arriving token's label and destination are folded by XOR into a short set index. That index reads one entry from each of a number of parallel ways. Each way is a small array with a valid bit per entry. If a valid entry holds the same label and destination, the two tokens leave together as an ordered operand pair and the entry is released. If no entry matches, the token is parked in the lowest-numbered empty way of that set to wait for its partner. If the set has no empty way, the block raises a sticky overflow flag and stops taking input until it is reset. Both the input and the pair output use valid/ready handshakes.

Top module: `token_match_unit`

## Requirements
- R1: A token is 96 bits. Bits [31:0] hold the value, [49:32] the destination, [85:50] the label and [95:86] type/control. Bit 86, the lowest control bit, is the operand port: 0 selects the left operand and 1 the right.
- R2: The set index is an XOR fold of the 54-bit key, which is token bits [85:32] with key bit 0 at token bit 32. Index bit j is the XOR of every key bit i for which i mod IDX_W equals j. Tokens in different sets never compete for ways.
- R3: A token that finds no partner produces no output and is stored in an empty way of its set. A set holds NUM_BANKS tokens with distinct tags before it is full.
- R4: A token whose label and destination equal those of a stored valid entry produces a pair. The pair holds both tokens, and their label and destination fields agree.
- R5: In a pair, if the arriving token has port bit 1, it goes on the right output and the stored token on the left. Otherwise the arriving token goes on the left and the stored token on the right.
- R6: A match releases the stored entry. A later token with the same tag is stored again rather than paired with the consumed one.
- R7: Value and control bits are not part of the comparison. Tokens with the same tag pair up even when their values and control fields differ.
- R8: Tokens with the same label but different destinations do not pair.
- R9: in_ready is low from the cycle after an accepted token until that token has been handled. On a match, out_valid rises after the second clock edge counted from acceptance. On a miss, no output appears and in_ready returns after the third edge. A miss therefore takes one cycle more than a match.
- R10: While out_valid is high and out_ready is low, out_valid and both pair outputs hold their values.
- R11: A miss in a full set asserts overflow after the second edge from acceptance. overflow then stays high, with in_ready and out_valid low, until reset.
- R12: After reset, in_ready is high, out_valid and overflow are low, and every way is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming token is valid |
| in_ready | output | 1 | Block can accept a token |
| in_token | input | 96 | Incoming token |
| out_valid | output | 1 | Operand pair is valid |
| out_ready | input | 1 | Downstream takes the pair |
| out_left | output | 96 | Left-operand token of the pair |
| out_right | output | 96 | Right-operand token of the pair |
| overflow | output | 1 | Sticky: a set ran out of empty ways |

## Verification
Each token is presented on a falling edge and accepted on the next rising edge. After the first edge from acceptance the block is in its lookup cycle and shows nothing yet. After the second edge, a match shows out_valid, a miss shows in_ready still low, and a full set shows overflow. After the third edge a miss has returned in_ready. The bench samples on the falling edge after each of these rising edges, so every check lands in the cycle its result is due. Tokens that share a set are found by searching destinations with the bench's own XOR-fold model, which gives the expected set independently of the design.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
   localparam int VAL_W    = 32;
   localparam int DST_W    = 18;
   localparam int LBL_W    = 36;
   localparam int CTL_W    = 10;
   localparam int KEY_W    = LBL_W + DST_W;
   localparam int TOK_W    = CTL_W + LBL_W + DST_W + VAL_W;
   localparam int PORT_BIT = 0;  // bit within ctl: 0 = left operand, 1 = right

   typedef struct packed {
      logic [CTL_W-1:0] ctl;
      logic [LBL_W-1:0] label;
      logic [DST_W-1:0] dest;
      logic [VAL_W-1:0] value;
   } token_t;

   function automatic logic [KEY_W-1:0] key_of(token_t t);
      return {t.label, t.dest};
   endfunction
endpackage

// File: rtl/tmu_hash.sv
module tmu_hash
   import tmu_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic [KEY_W-1:0] key,
   output logic [IDX_W-1:0] idx
);
   localparam int NCH   = (KEY_W + IDX_W - 1) / IDX_W;
   localparam int PAD_W = NCH * IDX_W;

   logic [PAD_W-1:0] padded;
   assign padded = PAD_W'(key);

   // chain of XOR folds, one chunk of IDX_W key bits per stage
   for (genvar c = 0; c < NCH; c++) begin : g_fold
      logic [IDX_W-1:0] acc;
      if (c == 0) begin : g_first
         assign acc = padded[IDX_W-1:0];
      end else begin : g_next
         assign acc = g_fold[c-1].acc ^ padded[c*IDX_W +: IDX_W];
      end
   end

   assign idx = g_fold[NCH-1].acc;
endmodule

// File: rtl/tmu_pick.sv
module tmu_pick #(
   parameter int N     = 8,
   parameter int SEL_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [SEL_W-1:0] sel
);
   always_comb begin
      found = |req;
      sel   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) sel = SEL_W'(i);
      end
   end
endmodule

// File: rtl/tmu_bank.sv
module tmu_bank
   import tmu_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output token_t           rd_tok,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  token_t           wr_tok,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] vld;
   token_t           mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
      end else begin
         if (clr_en) vld[clr_idx] <= 1'b0;
         if (wr_en)  vld[wr_idx]  <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_tok;
   end

   assign rd_valid = vld[rd_idx];
   assign rd_tok   = mem[rd_idx];
endmodule

// File: rtl/token_match_unit.sv
module token_match_unit
   import tmu_pkg::*;
#(
   parameter int IDX_W     = 4,
   parameter int NUM_BANKS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [TOK_W-1:0] in_token,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [TOK_W-1:0] out_left,
   output logic [TOK_W-1:0] out_right,
   output logic             overflow
);
   localparam int WAY_W = $clog2(NUM_BANKS);

   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("token_match_unit: IDX_W out of range");
   end
   if (NUM_BANKS < 2) begin : g_bad_ways
      $error("token_match_unit: NUM_BANKS must be at least 2");
   end

   typedef enum logic [2:0] {S_IDLE, S_LOOK, S_STORE, S_PAIR, S_OVF} state_t;

   state_t           state;
   token_t           tok_q, left_q, right_q, hit_tok;
   logic [IDX_W-1:0] idx_q, idx_in;
   logic [WAY_W-1:0] way_q, hit_sel, free_sel;
   logic             hit_found, free_found;
   logic [NUM_BANKS-1:0] hit_vec, free_vec, rd_valid;
   token_t           rd_tok [NUM_BANKS];

   tmu_hash #(.IDX_W(IDX_W)) u_hash (
      .key (key_of(token_t'(in_token))),
      .idx (idx_in)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_way
      tmu_bank #(.IDX_W(IDX_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_idx   (idx_q),
         .rd_valid (rd_valid[b]),
         .rd_tok   (rd_tok[b]),
         .wr_en    (state == S_STORE && way_q == WAY_W'(b)),
         .wr_idx   (idx_q),
         .wr_tok   (tok_q),
         .clr_en   (state == S_LOOK && hit_found && hit_sel == WAY_W'(b)),
         .clr_idx  (idx_q)
      );
      assign hit_vec[b]  = rd_valid[b] && (key_of(rd_tok[b]) == key_of(tok_q));
      assign free_vec[b] = !rd_valid[b];
   end

   tmu_pick #(.N(NUM_BANKS), .SEL_W(WAY_W)) u_pick_hit (
      .req (hit_vec), .found (hit_found), .sel (hit_sel)
   );
   tmu_pick #(.N(NUM_BANKS), .SEL_W(WAY_W)) u_pick_free (
      .req (free_vec), .found (free_found), .sel (free_sel)
   );

   assign hit_tok = rd_tok[hit_sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         tok_q   <= '0;
         idx_q   <= '0;
         way_q   <= '0;
         left_q  <= '0;
         right_q <= '0;
      end else begin
         unique case (state)
            S_IDLE: if (in_valid) begin
               tok_q <= token_t'(in_token);
               idx_q <= idx_in;
               state <= S_LOOK;
            end
            S_LOOK: if (hit_found) begin
               if (tok_q.ctl[PORT_BIT]) begin
                  left_q  <= hit_tok;
                  right_q <= tok_q;
               end else begin
                  left_q  <= tok_q;
                  right_q <= hit_tok;
               end
               state <= S_PAIR;
            end else if (free_found) begin
               way_q <= free_sel;
               state <= S_STORE;
            end else begin
               state <= S_OVF;
            end
            S_STORE: state <= S_IDLE;
            S_PAIR:  if (out_ready) state <= S_IDLE;
            S_OVF:   state <= S_OVF;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign in_ready  = (state == S_IDLE);
   assign out_valid = (state == S_PAIR);
   assign overflow  = (state == S_OVF);
   assign out_left  = left_q;
   assign out_right = right_q;
endmodule

// File: rtl/token_match_unit_chk.sv
module token_match_unit_chk
   import tmu_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [TOK_W-1:0] out_left,
   input logic [TOK_W-1:0] out_right,
   input logic             overflow
);
   token_t lt, rt;
   assign lt = token_t'(out_left);
   assign rt = token_t'(out_right);

   AST_PAIR_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (key_of(lt) == key_of(rt))); // R4

   AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (!lt.ctl[PORT_BIT] || rt.ctl[PORT_BIT])); // R5

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (!in_ready && !out_valid)); // R9

   AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right))); // R10

   AST_OVF_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (!in_ready && !out_valid)); // R11

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow); // R11
endmodule

bind token_match_unit token_match_unit_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_left  (out_left),
   .out_right (out_right),
   .overflow  (overflow)
);

// File: tb/token_match_unit_tb.sv
module token_match_unit_tb;
   localparam int TW = 96;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [TW-1:0] in_token = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [TW-1:0] out_left, out_right;
   logic          overflow;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   token_match_unit #(.IDX_W(IW), .NUM_BANKS(8)) u_dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
      .in_token (in_token), .out_valid (out_valid), .out_ready (out_ready),
      .out_left (out_left), .out_right (out_right), .overflow (overflow)
   );

   // R1 layout: {ctl[95:86], label[85:50], dest[49:32], value[31:0]}, port = bit 86
   function automatic logic [TW-1:0] mk(logic [35:0] lbl, logic [17:0] dst,
                                       logic [31:0] val, logic [8:0] tag, logic port);
      return {tag, port, lbl, dst, val};
   endfunction

   // R2 model: index bit j = XOR of key bits i with i mod IW == j
   function automatic logic [IW-1:0] hfold(logic [TW-1:0] t);
      logic [IW-1:0] h = '0;
      for (int i = 0; i < 54; i++) h[i % IW] ^= t[32 + i];
      return h;
   endfunction

   task automatic check(bit ok, string rq, logic [TW-1:0] act, logic [TW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready === 1'b1, "R12 in_ready", TW'(in_ready), TW'(1));
      check(out_valid === 1'b0, "R12 out_valid", TW'(out_valid), TW'(0));
      check(overflow === 1'b0, "R12 overflow", TW'(overflow), TW'(0));
   endtask

   task automatic push(logic [TW-1:0] t);
      @(negedge clk);
      in_valid = 1'b1;
      in_token = t;
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   // miss: nothing after edge 2 with in_ready low, in_ready back after edge 3 (R3, R9)
   task automatic send_miss(logic [TW-1:0] t, string rq);
      push(t);
      repeat (2) @(negedge clk);
      check(out_valid === 1'b0, {rq, " miss gives no pair"}, TW'(out_valid), TW'(0));
      check(in_ready === 1'b0 && overflow === 1'b0, "R9 miss still busy after edge 2",
            TW'({overflow, in_ready}), TW'(0));
      @(negedge clk);
      check(in_ready === 1'b1 && out_valid === 1'b0, "R9 miss done after edge 3",
            TW'({out_valid, in_ready}), TW'(1));
   endtask

   // hit: pair after edge 2 (R4, R5, R9), optional hold cycles (R10)
   task automatic send_hit(logic [TW-1:0] t, logic [TW-1:0] el, logic [TW-1:0] er,
                           string rq, int hold);
      push(t);
      repeat (2) @(negedge clk);
      check(out_valid === 1'b1, "R9 pair due after edge 2", TW'(out_valid), TW'(1));
      check(out_left === el, {rq, " left operand"}, out_left, el);
      check(out_right === er, {rq, " right operand"}, out_right, er);
      for (int k = 0; k < hold; k++) begin
         @(negedge clk);
         check(out_valid === 1'b1 && out_left === el && out_right === er,
               "R10 pair held while stalled", out_left, el);
      end
      out_ready = 1'b1;
      @(posedge clk);
      #1 out_ready = 1'b0;
      @(negedge clk);
      check(out_valid === 1'b0 && in_ready === 1'b1, "R9 idle after handoff",
            TW'({out_valid, in_ready}), TW'(1));
   endtask

   task automatic t_basic();
      logic [TW-1:0] a0 = mk(36'h123456789, 18'h0_1234, 32'h1111_0000, 9'h0A5, 1'b0);
      logic [TW-1:0] a1 = mk(36'h123456789, 18'h0_1234, 32'h2222_0000, 9'h133, 1'b1);
      send_miss(a0, "R3");
      send_hit(a1, a0, a1, "R5 R7 incoming right", 0);
   endtask

   task automatic t_reverse();
      logic [TW-1:0] b1 = mk(36'hABCDE0001, 18'h2_0F0F, 32'hDEAD_BEEF, 9'h001, 1'b1);
      logic [TW-1:0] b0 = mk(36'hABCDE0001, 18'h2_0F0F, 32'hCAFE_F00D, 9'h1FE, 1'b0);
      send_miss(b1, "R3");
      send_hit(b0, b0, b1, "R5 incoming left", 0);
   endtask

   task automatic t_dest();
      logic [TW-1:0] p = mk(36'h0000F0F0F, 18'h00005, 32'h5, 9'h0, 1'b0);
      logic [TW-1:0] q = mk(36'h0000F0F0F, 18'h00006, 32'h6, 9'h0, 1'b1);
      logic [TW-1:0] p1 = mk(36'h0000F0F0F, 18'h00005, 32'h55, 9'h0, 1'b1);
      logic [TW-1:0] q0 = mk(36'h0000F0F0F, 18'h00006, 32'h66, 9'h0, 1'b0);
      send_miss(p, "R8");
      send_miss(q, "R8 other destination");
      send_hit(p1, p, p1, "R8 dest 5", 0);
      send_hit(q0, q0, q, "R8 dest 6", 0);
   endtask

   task automatic t_reuse();
      logic [TW-1:0] c0 = mk(36'h777777777, 18'h1_1111, 32'hA0, 9'h0, 1'b0);
      logic [TW-1:0] c1 = mk(36'h777777777, 18'h1_1111, 32'hA1, 9'h0, 1'b1);
      logic [TW-1:0] c2 = mk(36'h777777777, 18'h1_1111, 32'hA2, 9'h0, 1'b0);
      logic [TW-1:0] c3 = mk(36'h777777777, 18'h1_1111, 32'hA3, 9'h0, 1'b1);
      send_miss(c0, "R6");
      send_hit(c1, c0, c1, "R6 first pair", 3);
      send_miss(c2, "R6 slot released");
      send_hit(c3, c2, c3, "R6 second pair", 0);
   endtask

   task automatic t_fill();
      logic [35:0]   lbl = 36'h0BADC0DE5;
      logic [17:0]   col [10];
      logic [17:0]   off;
      logic [IW-1:0] tgt;
      int            n = 0;
      bit            have_off = 0;
      tgt = hfold(mk(lbl, 18'h0, 32'h0, 9'h0, 1'b0));
      for (int d = 0; d < 4096 && (n < 10 || !have_off); d++) begin
         if (hfold(mk(lbl, 18'(d), 32'h0, 9'h0, 1'b0)) == tgt) begin
            if (n < 10) begin col[n] = 18'(d); n++; end
         end else if (!have_off) begin
            off = 18'(d); have_off = 1;
         end
      end
      for (int k = 0; k < 8; k++) send_miss(mk(lbl, col[k], 32'(k), 9'h0, 1'b0), "R3 fill");
      send_miss(mk(lbl, off, 32'hF, 9'h0, 1'b0), "R2 other set unaffected");
      send_hit(mk(lbl, col[3], 32'h33, 9'h0, 1'b1), mk(lbl, col[3], 32'd3, 9'h0, 1'b0),
               mk(lbl, col[3], 32'h33, 9'h0, 1'b1), "R4 pair in full set", 0);
      send_miss(mk(lbl, col[8], 32'h8, 9'h0, 1'b0), "R3 released way reused");
      push(mk(lbl, col[9], 32'h9, 9'h0, 1'b0));
      repeat (2) @(negedge clk);
      check(overflow === 1'b1, "R11 R2 overflow in predicted set", TW'(overflow), TW'(1));
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(overflow === 1'b1 && in_ready === 1'b0 && out_valid === 1'b0,
               "R11 stalled until reset", TW'({overflow, in_ready, out_valid}), TW'(4));
      end
   endtask

   task automatic t_after_reset();
      logic [TW-1:0] a1 = mk(36'h0BADC0DE5, 18'h0, 32'h77, 9'h0, 1'b1);
      do_reset();
      send_miss(a1, "R12 ways empty after reset");
      send_hit(mk(36'h0BADC0DE5, 18'h0, 32'h78, 9'h0, 1'b0),
               mk(36'h0BADC0DE5, 18'h0, 32'h78, 9'h0, 1'b0), a1, "R12 R5 pair after reset", 0);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      t_basic();
      t_reverse();
      t_dest();
      t_reuse();
      t_fill();
      t_after_reset();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule